// File: doc/BRIEF.md
# ECP Extended Register Window with Test FIFO

This block implements the extended register window that an ECP-capable parallel port places above its base registers. It decodes three byte-wide registers from a 3-bit offset. Offset 2 is the extended control register. It holds the operating mode and the hardware-maintained FIFO status. Offset 1 is a configuration byte that software can read and write. Offset 0 has two roles. In the FIFO-test mode it is a push/pop port into a small circular FIFO. In every other mode it is a plain storage byte.

Software uses the test mode to exercise the FIFO without any cable traffic. It pushes bytes, watches the status field change between empty, partly filled and full, and pops the bytes back in order. Any write to the extended control register that changes the mode flushes the FIFO. Read data is registered and appears one cycle after the read strobe.

Top module: `ecp_ext_regs`

## Requirements
- R1: After reset the control register (offset 2) reads 0x01, which is compatible mode (000) with the empty status. Offsets 0 and 1 read 0x00.
- R2: Control register layout: bits 7:5 are the mode (110 = FIFO test; the other codes are compatible 000, byte 001, PP-FIFO 010, ECP-FIFO 011, EPP 100, reserved 101, configuration 111). Bits 4:2 read back the value last written. Bits 1:0 are status: 01 empty, 10 full, 00 holding data; 11 never occurs. Software writes to bits 1:0 are ignored.
- R3: In test mode a write to offset 0 stores the byte at the write pointer and advances it. If the pointer was at the last slot (DEPTH-1), the status becomes full and the pointer wraps to 0. Otherwise the status becomes 00.
- R4: In test mode a read of offset 0 returns the entry at the read pointer and advances the pointer with wrap. If the advanced read pointer equals the write pointer, the status becomes empty. Otherwise it becomes 00. Bytes come out in the order they were pushed.
- R5: A push while full is dropped and leaves the pointers and status unchanged. A pop while empty is dropped and returns 0xFF.
- R6: A control-register write whose mode field differs from the current mode resets both pointers and sets the status to empty. A write with the same mode field leaves the FIFO contents and status intact.
- R7: Outside test mode, offset 0 reads and writes a plain byte register. Test-mode accesses do not alter that register.
- R8: Offset 1 is a read/write configuration byte. Offsets 3 to 7 ignore writes and read 0xFF.
- R9: Read data appears on the cycle after the read strobe and holds until the next read. When the write and read strobes are both asserted, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset within the window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The hardest state to reach is the pointer-wrap corner. Here the write pointer reaches the last slot while holding only a single entry, so the status reports full with one byte stored. The drain must then still end in empty.

The stimulus gets there in steps. It fills and drains the FIFO completely. It then does one push/pop pair so the read pointer sits at the last slot. The next push lands in that slot and wraps the write pointer. The status and the popped byte are then checked.

Flushing is reached by leaving test mode with data still queued. The bench returns to test mode and confirms that a pop finds the FIFO empty.

// File: rtl/ecp_ext_regs.sv
module ecp_ext_regs #(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [2:0] MODE_COMPAT = 3'b000;
  localparam logic [2:0] MODE_TEST   = 3'b110;
  localparam logic [1:0] ST_SOME  = 2'b00;
  localparam logic [1:0] ST_EMPTY = 2'b01;
  localparam logic [1:0] ST_FULL  = 2'b10;

  logic [2:0]    mode_q, misc_q;
  logic [1:0]    st_q;
  logic [7:0]    plain_q, cfgb_q, rdata_q;
  logic [7:0]    fifo_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [7:0]    rd_mux;

  wire wr_acc    = bus_wr;
  wire rd_acc    = bus_rd & ~bus_wr;
  wire sel0      = (bus_addr == 3'd0);
  wire sel1      = (bus_addr == 3'd1);
  wire sel2      = (bus_addr == 3'd2);
  wire test_mode = (mode_q == MODE_TEST);
  wire push      = wr_acc & sel0 & test_mode & (st_q != ST_FULL);
  wire pop       = rd_acc & sel0 & test_mode & (st_q != ST_EMPTY);
  wire ecr_wr    = wr_acc & sel2;
  wire mode_chg  = ecr_wr & (bus_wdata[7:5] != mode_q);
  wire wlast     = (wptr_q == LAST);
  wire [PW-1:0] wptr_inc = wlast ? '0 : wptr_q + 1'b1;
  wire [PW-1:0] rptr_inc = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;

  always_comb begin
    case (bus_addr)
      3'd0:    rd_mux = test_mode ? ((st_q == ST_EMPTY) ? 8'hFF : fifo_q[rptr_q]) : plain_q;
      3'd1:    rd_mux = cfgb_q;
      3'd2:    rd_mux = {mode_q, misc_q, st_q};
      default: rd_mux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_COMPAT;
      misc_q  <= '0;
      st_q    <= ST_EMPTY;
      plain_q <= '0;
      cfgb_q  <= '0;
      rdata_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      for (int i = 0; i < DEPTH; i++) fifo_q[i] <= '0;
    end else begin
      if (wr_acc && sel0 && !test_mode) plain_q <= bus_wdata;
      if (wr_acc && sel1) cfgb_q <= bus_wdata;
      if (ecr_wr) begin
        mode_q <= bus_wdata[7:5];
        misc_q <= bus_wdata[4:2];
      end
      if (mode_chg) begin
        wptr_q <= '0;
        rptr_q <= '0;
        st_q   <= ST_EMPTY;
      end else if (push) begin
        fifo_q[wptr_q] <= bus_wdata;
        wptr_q <= wptr_inc;
        st_q   <= wlast ? ST_FULL : ST_SOME;
      end else if (pop) begin
        rptr_q <= rptr_inc;
        st_q   <= (rptr_inc == wptr_q) ? ST_EMPTY : ST_SOME;
      end
      if (rd_acc) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;

  AST_FLAGS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) st_q != 2'b11); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (st_q == ST_EMPTY && wptr_q == '0 && rptr_q == '0)); // R6
  AST_PUSH_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && sel0 && test_mode && st_q == ST_FULL) |=> (st_q == ST_FULL && $stable(wptr_q))); // R5
  AST_POP_EMPTY_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && sel0 && test_mode && st_q == ST_EMPTY) |=> (bus_rdata == 8'hFF && $stable(rptr_q))); // R5
  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && bus_addr >= 3'd3) |=> bus_rdata == 8'hFF); // R8
  AST_PLAIN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && sel0 && test_mode) |=> $stable(plain_q)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata)); // R9
endmodule

// File: tb/ecp_ext_regs_tb.sv
`timescale 1ns/1ps
module ecp_ext_regs_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic       bus_rd = 0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit pend = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  ecp_ext_regs #(.DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  always @(posedge clk) pend <= rst_n && bus_rd && !bus_wr;

  initial begin
    forever begin
      @(negedge clk);
      if (pend && exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_addr = a; bus_wr = 0; bus_rd = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2, 8'h01, "R1 ecr reset");
    rd(0, 8'h00, "R1 plain reset");
    rd(1, 8'h00, "R1 cfgb reset");
    wr(0, 8'hA5);
    rd(0, 8'hA5, "R7 plain byte");
    wr(1, 8'h3C);
    rd(1, 8'h3C, "R8 cfgb rw");
    wr(5, 8'h12);
    rd(5, 8'hFF, "R8 offset5");
    rd(3, 8'hFF, "R8 offset3");
    wr(2, 8'hDE);
    rd(2, 8'hDD, "R2 mode and status ignore");
    rd(0, 8'hFF, "R5 pop empty");
    rd(2, 8'hDD, "R5 empty unchanged");
    wr(0, 8'h11);
    rd(2, 8'hDC, "R3 some data");
    wr(0, 8'h22);
    rd(2, 8'hDE, "R3 full");
    wr(0, 8'h33);
    rd(2, 8'hDE, "R5 push full dropped");
    rd(0, 8'h11, "R4 pop first");
    rd(2, 8'hDC, "R4 some after pop");
    rd(0, 8'h22, "R4 pop second");
    rd(2, 8'hDD, "R4 empty after drain");
    rd(0, 8'hFF, "R5 pop empty again");
    wr(0, 8'h44);
    rd(0, 8'h44, "R4 single pop");
    wr(0, 8'h55);
    rd(2, 8'hDE, "R3 wrap sets full");
    rd(0, 8'h55, "R4 pop wrapped slot");
    rd(2, 8'hDD, "R4 empty after wrap");
    wr(0, 8'h66);
    wr(2, 8'hC4);
    rd(2, 8'hC4, "R6 same mode keeps data");
    rd(0, 8'h66, "R6 data survives");
    rd(2, 8'hC5, "R6 empty after pop");
    wr(0, 8'h77);
    wr(2, 8'h20);
    rd(2, 8'h21, "R6 flush on mode change");
    rd(0, 8'hA5, "R7 plain retained");
    wr(2, 8'hC0);
    rd(2, 8'hC1, "R6 test mode empty");
    rd(0, 8'hFF, "R6 flushed pop");
    @(negedge clk);
    bus_addr = 1; bus_wdata = 8'h99; bus_wr = 1; bus_rd = 1;
    idle();
    rd(1, 8'h99, "R9 write wins");
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (bus_rdata !== 8'h99) begin
      fails++;
      $display("FAIL R9 hold actual %02h expected 99", bus_rdata);
    end
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule